// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Snooping

This block holds a small set of waiting instructions for one class of functional unit in a dynamically scheduled core. At issue, each instruction brings an opcode and two source operands. Each operand arrives either as a ready value or as the tag of the station that will produce it. The instruction takes the lowest-numbered free slot, and that slot's fixed name becomes the tag of its result. While an entry waits, it watches the single common result bus. When a broadcast carries a tag that one of its operands is waiting for, the entry takes the value from the bus.

When both operands are present, the entry can be sent to the functional unit. The lowest-numbered ready entry goes first, and only one entry is sent per cycle. When the unit returns the result under the entry's name, the entry asks for the result bus. The entry stays occupied until a grant arrives for its request. When every entry is occupied, the block raises a stall so that the in-order front end holds the instruction it is trying to issue.

Top module: `rs_pool`

## Requirements
- R1: An issue request with `issue_stall` low fills the lowest-numbered free entry. Entry i carries the name BASE_TAG+i, which `issue_tag` shows. When all entries are busy, `issue_stall` is high and the request changes no entry.
- R2: Tag value 0 means "value present". An operand issued with tag 0 keeps the value given at issue. A nonzero tag means the operand waits for a broadcast of that tag.
- R3: An entry is offered for dispatch only when neither operand is still waiting. A single missing operand keeps `disp_valid` low.
- R4: A broadcast that supplies an entry's last missing operand makes that entry dispatchable in the same cycle. The broadcast value appears on the dispatch operand.
- R5: When both operands wait on the same tag, one matching broadcast fills both in that cycle.
- R6: An entry whose operands both have tag 0 at issue is offered for dispatch in the cycle right after the issue edge.
- R7: Once issued, an entry's operand tags change only through a matching broadcast. Broadcasts of other tags leave the entry waiting.
- R8: If the result bus broadcasts a source's tag in the same cycle that source is issued, the entry captures the value at issue and does not wait.
- R9: When several entries are ready, the lowest-numbered one is dispatched. At most one entry dispatches per cycle.
- R10: A functional-unit result whose tag names an executing entry makes that entry request the bus. `cdb_req_tag` is the entry's own name and `cdb_req_value` is the result. When several entries hold results, the lowest-numbered one requests first.
- R11: A request without a grant stays asserted in later cycles, and the entry stays busy.
- R12: A granted entry becomes free at that clock edge, so `issue_stall` is low in the following cycle and the entry can be refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Issue request |
| issue_op | input | OP_W | Opcode of issued instruction |
| issue_vj | input | XLEN | First source value (used when tag is 0) |
| issue_qj | input | TAG_W | First source producer tag, 0 = ready |
| issue_vk | input | XLEN | Second source value |
| issue_qk | input | TAG_W | Second source producer tag, 0 = ready |
| issue_stall | output | 1 | All entries busy; issue refused |
| issue_tag | output | TAG_W | Name that the next accepted issue receives |
| cdb_valid | input | 1 | Result bus carries a broadcast |
| cdb_tag | input | TAG_W | Tag of broadcast result |
| cdb_value | input | XLEN | Broadcast value |
| disp_valid | output | 1 | An entry is dispatched this cycle |
| disp_op | output | OP_W | Opcode of dispatched entry |
| disp_vj | output | XLEN | First operand of dispatched entry |
| disp_vk | output | XLEN | Second operand of dispatched entry |
| disp_tag | output | TAG_W | Name of dispatched entry |
| fu_done | input | 1 | Functional unit returns a result |
| fu_tag | input | TAG_W | Entry name of returned result |
| fu_value | input | XLEN | Returned result |
| cdb_req | output | 1 | Request to broadcast a result |
| cdb_req_tag | output | TAG_W | Own name of requesting entry |
| cdb_req_value | output | XLEN | Result to broadcast |
| cdb_grant | input | 1 | Grant for the current request |

## Verification
Some properties are checked on every cycle. An entry is sent only while ready, and at most one entry is sent per cycle. Waiting tags stay put unless a broadcast arrives. An ungranted result keeps requesting, every request carries one of the pool's own names, and a grant removes the stall in the next cycle. Other behaviours depend on what reaches the pool and can only be shown by the bench's scenarios: bypassing a value into the same-cycle dispatch, filling both operands from one broadcast, capturing a value at issue, choosing among several ready entries, and refusing an issue when the pool is full. The bench covers these with directed sequences and with random traffic checked against a model.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } rs_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int unsigned N  = 4,
    localparam int unsigned IW = rsp_pkg::idx_width(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  gnt
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
                gnt = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rsp_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OP_W  = 4,
    parameter int unsigned TAG_W = 4,
    parameter logic [TAG_W-1:0] MY_TAG = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic [OP_W-1:0]  in_op,
    input  logic [XLEN-1:0]  in_vj,
    input  logic [TAG_W-1:0] in_qj,
    input  logic [XLEN-1:0]  in_vk,
    input  logic [TAG_W-1:0] in_qk,
    input  logic             cdb_v,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_val,
    input  logic             go,
    input  logic             fu_done,
    input  logic [TAG_W-1:0] fu_tag,
    input  logic [XLEN-1:0]  fu_val,
    input  logic             grant,
    output logic             busy,
    output logic             ready,
    output logic             done,
    output logic [OP_W-1:0]  op_o,
    output logic [XLEN-1:0]  vj_o,
    output logic [XLEN-1:0]  vk_o
);
    typedef struct packed {
        logic [TAG_W-1:0] q;
        logic [XLEN-1:0]  v;
    } opnd_t;

    function automatic opnd_t snoop(input opnd_t o, input logic v,
                                    input logic [TAG_W-1:0] t,
                                    input logic [XLEN-1:0] d);
        opnd_t r = o;
        if (o.q != '0 && v && o.q == t) begin
            r.q = '0;
            r.v = d;
        end
        return r;
    endfunction

    rs_state_e        st;
    logic [OP_W-1:0]  op_q;
    opnd_t            oj, ok;
    opnd_t            oj_now, ok_now;

    // operand view including the broadcast of this cycle (bypass)
    assign oj_now = snoop(oj, cdb_v, cdb_tag, cdb_val);
    assign ok_now = snoop(ok, cdb_v, cdb_tag, cdb_val);

    assign busy  = (st != ST_FREE);
    assign done  = (st == ST_DONE);
    assign ready = (st == ST_WAIT) && (oj_now.q == '0) && (ok_now.q == '0);
    assign op_o  = op_q;
    assign vj_o  = oj_now.v;   // holds the result once DONE
    assign vk_o  = ok_now.v;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_FREE;
            op_q <= '0;
            oj   <= '0;
            ok   <= '0;
        end else begin
            unique case (st)
                ST_FREE: if (alloc) begin
                    st   <= ST_WAIT;
                    op_q <= in_op;
                    oj   <= snoop('{q: in_qj, v: in_vj}, cdb_v, cdb_tag, cdb_val);
                    ok   <= snoop('{q: in_qk, v: in_vk}, cdb_v, cdb_tag, cdb_val);
                end
                ST_WAIT: begin
                    oj <= oj_now;
                    ok <= ok_now;
                    if (go) st <= ST_EXEC;
                end
                ST_EXEC: if (fu_done && fu_tag == MY_TAG) begin
                    st   <= ST_DONE;
                    oj.v <= fu_val;
                end
                ST_DONE: if (grant) st <= ST_FREE;
                default: st <= ST_FREE;
            endcase
        end
    end

    // R3: dispatch selection only ever picks a ready entry
    a_r3_go_needs_ready: assert property (@(posedge clk) disable iff (rst)
        go |-> ready);

    // R7: with no broadcast, a waiting entry's tags do not move
    a_r7_tags_frozen: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !cdb_v && !go) |=> (oj.q == $past(oj.q) && ok.q == $past(ok.q)));

    // R11: an entry holding a result stays until granted
    a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && !grant) |=> (st == ST_DONE));
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rsp_pkg::*;
#(
    parameter int unsigned NUM_ST   = 4,
    parameter int unsigned XLEN     = 32,
    parameter int unsigned OP_W     = 4,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned BASE_TAG = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [OP_W-1:0]  issue_op,
    input  logic [XLEN-1:0]  issue_vj,
    input  logic [TAG_W-1:0] issue_qj,
    input  logic [XLEN-1:0]  issue_vk,
    input  logic [TAG_W-1:0] issue_qk,
    output logic             issue_stall,
    output logic [TAG_W-1:0] issue_tag,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_value,
    output logic             disp_valid,
    output logic [OP_W-1:0]  disp_op,
    output logic [XLEN-1:0]  disp_vj,
    output logic [XLEN-1:0]  disp_vk,
    output logic [TAG_W-1:0] disp_tag,
    input  logic             fu_done,
    input  logic [TAG_W-1:0] fu_tag,
    input  logic [XLEN-1:0]  fu_value,
    output logic             cdb_req,
    output logic [TAG_W-1:0] cdb_req_tag,
    output logic [XLEN-1:0]  cdb_req_value,
    input  logic             cdb_grant
);
    localparam int unsigned IW = idx_width(NUM_ST);

    logic [NUM_ST-1:0] busy, ready, done, alloc, go, grant;
    logic [NUM_ST-1:0] free_gnt, disp_gnt, req_gnt;
    logic [OP_W-1:0]   op_a [NUM_ST];
    logic [XLEN-1:0]   vj_a [NUM_ST];
    logic [XLEN-1:0]   vk_a [NUM_ST];
    logic [IW-1:0]     free_idx, disp_idx, req_idx;
    logic              any_free, any_ready, any_done;

    rs_pick #(.N(NUM_ST)) u_free (.req(~busy), .any(any_free),  .idx(free_idx), .gnt(free_gnt));
    rs_pick #(.N(NUM_ST)) u_disp (.req(ready), .any(any_ready), .idx(disp_idx), .gnt(disp_gnt));
    rs_pick #(.N(NUM_ST)) u_req  (.req(done),  .any(any_done),  .idx(req_idx),  .gnt(req_gnt));

    assign issue_stall = !any_free;
    assign issue_tag   = TAG_W'(BASE_TAG) + TAG_W'(free_idx);
    assign alloc       = (issue_valid && any_free) ? free_gnt : '0;
    assign go          = disp_gnt;
    assign grant       = cdb_grant ? req_gnt : '0;

    generate
        for (genvar g = 0; g < NUM_ST; g++) begin : g_ent
            rs_entry #(
                .XLEN(XLEN), .OP_W(OP_W), .TAG_W(TAG_W),
                .MY_TAG(TAG_W'(BASE_TAG + g))
            ) u_ent (
                .clk(clk), .rst(rst), .alloc(alloc[g]),
                .in_op(issue_op), .in_vj(issue_vj), .in_qj(issue_qj),
                .in_vk(issue_vk), .in_qk(issue_qk),
                .cdb_v(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_value),
                .go(go[g]), .fu_done(fu_done), .fu_tag(fu_tag), .fu_val(fu_value),
                .grant(grant[g]), .busy(busy[g]), .ready(ready[g]), .done(done[g]),
                .op_o(op_a[g]), .vj_o(vj_a[g]), .vk_o(vk_a[g])
            );
        end
    endgenerate

    assign disp_valid    = any_ready;
    assign disp_op       = op_a[disp_idx];
    assign disp_vj       = vj_a[disp_idx];
    assign disp_vk       = vk_a[disp_idx];
    assign disp_tag      = TAG_W'(BASE_TAG) + TAG_W'(disp_idx);
    assign cdb_req       = any_done;
    assign cdb_req_tag   = TAG_W'(BASE_TAG) + TAG_W'(req_idx);
    assign cdb_req_value = vj_a[req_idx];

    // R9: never more than one entry leaves per cycle
    a_r9_one_dispatch: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go));

    // R10: a request always carries one of this pool's names
    a_r10_req_own_name: assert property (@(posedge clk) disable iff (rst)
        cdb_req |-> (int'(cdb_req_tag) >= BASE_TAG && int'(cdb_req_tag) < BASE_TAG + NUM_ST));

    // R11: an ungranted request is still there next cycle
    a_r11_req_persists: assert property (@(posedge clk) disable iff (rst)
        (cdb_req && !cdb_grant) |=> cdb_req);

    // R12: a grant frees a slot for the next cycle
    a_r12_free_after_grant: assert property (@(posedge clk) disable iff (rst)
        (cdb_req && cdb_grant) |=> !issue_stall);

    // R1: a full pool stays full when nothing is granted
    a_r1_full_holds: assert property (@(posedge clk) disable iff (rst)
        (issue_stall && !(cdb_req && cdb_grant)) |=> issue_stall);
endmodule

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
    localparam int N = 4;

    logic clk = 0, rst = 1;
    always #5 clk = ~clk;

    logic        issue_valid = 0;
    logic [3:0]  issue_op = 0, issue_qj = 0, issue_qk = 0;
    logic [31:0] issue_vj = 0, issue_vk = 0;
    logic        issue_stall;
    logic [3:0]  issue_tag;
    logic        cdb_valid = 0;
    logic [3:0]  cdb_tag = 0;
    logic [31:0] cdb_value = 0;
    logic        disp_valid;
    logic [3:0]  disp_op, disp_tag;
    logic [31:0] disp_vj, disp_vk;
    logic        fu_done = 0;
    logic [3:0]  fu_tag = 0;
    logic [31:0] fu_value = 0;
    logic        cdb_req;
    logic [3:0]  cdb_req_tag;
    logic [31:0] cdb_req_value;
    logic        cdb_grant = 0;

    rs_pool dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model: 0 free, 1 waiting, 2 executing, 3 holding result
    int          m_st [N];
    logic [3:0]  m_op [N], m_qj [N], m_qk [N];
    logic [31:0] m_vj [N], m_vk [N];
    int          p_alloc, p_disp, p_req;
    logic [31:0] p_dj, p_dk;
    logic        pend_v = 0;
    logic [3:0]  pend_t = 0;
    logic [31:0] pend_d = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic resolved(input logic [3:0] q);
        return (q == 0) || (cdb_valid && q == cdb_tag);
    endfunction

    function automatic logic [31:0] eff(input logic [3:0] q, input logic [31:0] v);
        return (q != 0 && cdb_valid && q == cdb_tag) ? cdb_value : v;
    endfunction

    // mode 0: bus driven by caller; 1: random traffic; 2: grant with loopback
    task automatic eval(input int mode);
        #1;
        if (mode == 2 || (mode == 1 && cdb_req && $urandom_range(1, 0) == 1)) begin
            cdb_grant = cdb_req;
            cdb_valid = cdb_req;
            cdb_tag   = cdb_req_tag;
            cdb_value = cdb_req_value;
        end else if (mode == 1) begin
            cdb_grant = 0;
            cdb_valid = ($urandom_range(1, 0) == 1);
            cdb_tag   = 4'($urandom_range(15, 5));
            cdb_value = $urandom;
        end
        #1;
        p_alloc = -1; p_disp = -1; p_req = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_st[i] == 0) p_alloc = i;
            if (m_st[i] == 1 && resolved(m_qj[i]) && resolved(m_qk[i])) p_disp = i;
            if (m_st[i] == 3) p_req = i;
        end
        chk("R12 stall", issue_stall, p_alloc < 0);
        if (p_alloc >= 0) chk("R1 issue name", issue_tag, p_alloc + 1);
        chk("R3 dispatch valid", disp_valid, p_disp >= 0);
        if (p_disp >= 0) begin
            p_dj = eff(m_qj[p_disp], m_vj[p_disp]);
            p_dk = eff(m_qk[p_disp], m_vk[p_disp]);
            chk("R9 dispatch name", disp_tag, p_disp + 1);
            chk("R4 dispatch vj", disp_vj, p_dj);
            chk("R4 dispatch vk", disp_vk, p_dk);
            chk("R9 dispatch op", disp_op, m_op[p_disp]);
        end
        chk("R11 bus request", cdb_req, p_req >= 0);
        if (p_req >= 0) begin
            chk("R10 request name", cdb_req_tag, p_req + 1);
            chk("R10 request value", cdb_req_value, m_vj[p_req]);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            case (m_st[i])
                0: if (issue_valid && p_alloc == i) begin
                    m_st[i] = 1; m_op[i] = issue_op;
                    m_vj[i] = eff(issue_qj, issue_vj); m_qj[i] = resolved(issue_qj) ? 4'd0 : issue_qj;
                    m_vk[i] = eff(issue_qk, issue_vk); m_qk[i] = resolved(issue_qk) ? 4'd0 : issue_qk;
                end
                1: begin
                    m_vj[i] = eff(m_qj[i], m_vj[i]); if (resolved(m_qj[i])) m_qj[i] = 0;
                    m_vk[i] = eff(m_qk[i], m_vk[i]); if (resolved(m_qk[i])) m_qk[i] = 0;
                    if (p_disp == i) m_st[i] = 2;
                end
                2: if (fu_done && fu_tag == 4'(i + 1)) begin m_st[i] = 3; m_vj[i] = fu_value; end
                3: if (cdb_grant && p_req == i) m_st[i] = 0;
                default: ;
            endcase
        end
        pend_v = (p_disp >= 0);
        pend_t = 4'(p_disp + 1);
        pend_d = p_dj + p_dk + 32'(m_op[p_disp < 0 ? 0 : p_disp]);
        @(negedge clk);
        issue_valid = 0; cdb_valid = 0; cdb_grant = 0;
        fu_done = pend_v; fu_tag = pend_t; fu_value = pend_d;
    endtask

    task automatic issue(input logic [3:0] op, input logic [3:0] qj, input logic [31:0] vj,
                         input logic [3:0] qk, input logic [31:0] vk);
        issue_valid = 1; issue_op = op;
        issue_qj = qj; issue_vj = vj; issue_qk = qk; issue_vk = vk;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_op[i] = 0; m_qj[i] = 0; m_qk[i] = 0; m_vj[i] = 0; m_vk[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // reset state
        #1;
        chk("R12 reset stall", issue_stall, 0);
        chk("R3 reset dispatch", disp_valid, 0);
        chk("R11 reset request", cdb_req, 0);
        chk("R1 reset name", issue_tag, 1);

        // R6/R2: both operands ready at issue -> dispatch next cycle with the issued values
        issue(4'd3, 0, 32'd10, 0, 32'd20); eval(0); tick();
        eval(0);
        chk("R6 ready next cycle", disp_valid, 1);
        chk("R6 dispatch name", disp_tag, 1);
        chk("R2 issued value kept", disp_vj, 32'd10);
        tick();

        // R5/R3/R7: both operands wait on tag 7
        issue(4'd1, 4'd7, 0, 4'd7, 0); eval(0); tick();
        eval(0);
        chk("R3 waiting not dispatched", disp_valid, 0); tick();
        cdb_valid = 1; cdb_tag = 4'd8; cdb_value = 32'hdead;
        eval(0);
        chk("R7 other tag ignored", disp_valid, 0); tick();
        eval(0);
        chk("R7 still waiting", disp_valid, 0);
        chk("R11 result held without grant", cdb_req, 1);
        tick();
        cdb_valid = 1; cdb_tag = 4'd7; cdb_value = 32'd55;
        eval(0);
        chk("R4 same-cycle dispatch", disp_valid, 1);
        chk("R5 vj from one broadcast", disp_vj, 32'd55);
        chk("R5 vk from one broadcast", disp_vk, 32'd55);
        tick();

        // R8: broadcast of the source tag during the issue cycle
        issue(4'd2, 4'd9, 0, 0, 32'd5);
        cdb_valid = 1; cdb_tag = 4'd9; cdb_value = 32'd77;
        eval(0); tick();
        eval(0);
        chk("R8 captured at issue", disp_valid, 1);
        chk("R8 captured value", disp_vj, 32'd77);
        tick();

        // fill the pool, try an issue while full (R1)
        issue(4'd4, 4'd12, 0, 0, 32'd1); eval(0); tick();
        issue(4'd5, 0, 32'd2, 0, 32'd3); eval(0);
        chk("R1 stall when full", issue_stall, 1); tick();
        eval(0);
        chk("R1 refused issue left no dispatch", disp_valid, 0); tick();

        // grant one result -> free next cycle (R12)
        eval(2); tick();
        eval(0);
        chk("R12 free after grant", issue_stall, 0);
        chk("R12 refill name", issue_tag, 1);
        issue(4'd6, 4'd12, 0, 0, 32'd4); tick();

        // R9: two entries released by one broadcast
        cdb_valid = 1; cdb_tag = 4'd12; cdb_value = 32'd100;
        eval(0);
        chk("R9 lowest ready first", disp_tag, 1); tick();
        eval(0);
        chk("R9 next ready follows", disp_tag, 4); tick();

        // random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(1, 0) == 1)
                issue(4'($urandom), ($urandom_range(2, 0) == 0) ? 4'd0 : 4'($urandom_range(15, 5)),
                      $urandom, ($urandom_range(2, 0) == 0) ? 4'd0 : 4'($urandom_range(15, 5)),
                      $urandom);
            eval(1);
            tick();
        end
        finish_run();
    end
endmodule